// File: doc/BRIEF.md
# Serial Port Status Flag and Interrupt Controller

This block sits between a processor bus and the bit-level shifters of an asynchronous serial port. It holds a small control register with two interrupt enables and a transmitter enable, and a status register with five sticky flags: transmit holding register empty, receive holding register full, overrun, framing error and parity error. It also holds one byte waiting to be sent and one byte that has been received. The shifters, baud timing and frame format live elsewhere. They reach this block through a short handshake: a load request with a loaded strobe on the transmit side, and a completion strobe with data and error bits on the receive side.

Software must follow two rules that differ from a plain write-to-send port. First, writing the holding register does not start a transfer. Software starts it by clearing the empty flag. Second, any status flag clears only when software writes 0 to it after a status read has returned it as 1. Stray writes therefore cannot lose an event. The block drives three registered, level-sensitive, active-high interrupt lines from the flags and the enables.

Top module: `sci_flag_ctrl`

## Requirements
- R1: After reset the control register reads 0x00, the status register reads 0x80 (only the empty flag set), all three interrupt outputs are low and `load_req` is low.
- R2: The register map is: address 0 control, 1 status, 2 transmit holding (write and read back), 3 receive holding (read only). In the control register, bit 7 is the transmit interrupt enable, bit 6 the receive interrupt enable and bit 5 the transmitter enable. Control bits 4..0 read as 0 and ignore writes.
- R3: `irq_tx` equals (empty flag AND transmit interrupt enable), registered, so it follows a change of either one clock later.
- R4: The receive interrupt enable alone gates both receive interrupts. `irq_rx` follows the full flag, and `irq_err` follows the OR of the overrun, framing and parity flags, each registered one clock later. Clearing the enable drops both lines one clock later while the flags stay set.
- R5: A `rx_done` strobe while the full flag is 0 stores `rx_data` in the receive holding register and sets the full flag (status bit 6). It sets the framing flag (bit 4) if `rx_frame_err` is 1 and the parity flag (bit 3) if `rx_par_err` is 1.
- R6: A `rx_done` strobe while the full flag is 1 sets the overrun flag (status bit 5). It leaves the receive holding register, the framing flag and the parity flag unchanged.
- R7: A status flag goes to 0 only when software writes 0 to its bit after a status read that returned it as 1. A write of 0 without such a read leaves the flag at 1.
- R8: Writing 1 to a status bit never changes that flag, even after it has been read as 1. Status bits 2..0 always read 0.
- R9: While the transmitter enable is 0, the empty flag (status bit 7) is held at 1, and writes of 0 to it have no effect. Clearing the enable while the flag is 0 returns it to 1.
- R10: `load_req` is 1 exactly when the transmitter is enabled, the empty flag is 0 and `sh_idle` is 1. `tx_data` always presents the transmit holding register.
- R11: A `sh_loaded` strobe sets the empty flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 2 | Register select: 0 control, 1 status, 2 transmit holding, 3 receive holding |
| bus_rd | input | 1 | Read strobe; a status read arms the clear of every flag it sees at 1 |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the selected register (combinational) |
| tx_data | output | DATA_W | Contents of the transmit holding register |
| load_req | output | 1 | Request to the transmit shifter to take `tx_data` |
| sh_idle | input | 1 | Transmit shifter is ready to accept a byte |
| sh_loaded | input | 1 | One-cycle strobe: shifter has taken the byte |
| rx_done | input | 1 | One-cycle strobe: a received frame is complete |
| rx_data | input | DATA_W | Received byte, valid with `rx_done` |
| rx_frame_err | input | 1 | Framing error of the frame, valid with `rx_done` |
| rx_par_err | input | 1 | Parity error of the frame, valid with `rx_done` |
| irq_tx | output | 1 | Transmit-empty interrupt |
| irq_rx | output | 1 | Receive-full interrupt |
| irq_err | output | 1 | Receive-error interrupt |

## Verification
A wrong flag or arm bit in this block does not stay hidden. It shows in the next status read, and its interrupt line shows it one clock after the flag register changes. A lost arm bit shows as a flag that refuses to clear after a proper read-then-write-zero. A spurious arm bit shows as a flag that a bare write of zero can clear. A corrupt receive hold shows only on a read of address 3. The bench therefore follows every event with an immediate status read and checks the interrupt lines exactly one clock after each change. It sweeps all combinations of the two receive error bits and the receive enable, both with and without overrun.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
    // register addresses
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_TXH  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_RXH  = 2'd3;

    // byte-wide control and status layout
    localparam int REG_W    = 8;
    localparam int CTL_TIE  = 7;
    localparam int CTL_RIE  = 6;
    localparam int CTL_TE   = 5;
    localparam int STAT_TOP = 7;

    // flag indices; status bit = STAT_TOP - index
    localparam int NFLAG = 5;
    localparam int F_TXE = 0;
    localparam int F_RXF = 1;
    localparam int F_ORE = 2;
    localparam int F_FER = 3;
    localparam int F_PER = 4;

    typedef struct packed {
        logic tie;
        logic rie;
        logic te;
    } ctrl_t;

    typedef struct packed {
        logic tx;
        logic rx;
        logic err;
    } irq_t;
endpackage

// File: rtl/sfc_flag.sv
// One sticky status flag with read-then-write-zero clearing.
module sfc_flag #(
    parameter bit RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic force_i,
    input  logic rd_hit_i,
    input  logic wr_zero_i,
    output logic flag_o
);
    typedef struct packed {
        logic flag;
        logic armed;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (force_i || set_i) begin
            // new event or forced value: any earlier read no longer counts
            st_d.flag  = 1'b1;
            st_d.armed = 1'b0;
        end else if (wr_zero_i && st_q.armed) begin
            st_d.flag  = 1'b0;
            st_d.armed = 1'b0;
        end else if (rd_hit_i && st_q.flag) begin
            st_d.armed = 1'b1;
        end
        if (!st_d.flag) begin
            st_d.armed = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{flag: RESET_VAL, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/sfc_irq.sv
// Registered interrupt outputs from flags and enables.
module sfc_irq
    import sfc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] flags_i,
    input  logic             tie_i,
    input  logic             rie_i,
    output irq_t             irq_o
);
    irq_t irq_d, irq_q;

    always_comb begin
        irq_d.tx  = flags_i[F_TXE] & tie_i;
        irq_d.rx  = flags_i[F_RXF] & rie_i;
        irq_d.err = (flags_i[F_ORE] | flags_i[F_FER] | flags_i[F_PER]) & rie_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= '0;
        end else begin
            irq_q <= irq_d;
        end
    end

    assign irq_o = irq_q;
endmodule

// File: rtl/sci_flag_ctrl.sv
// Serial port status flags, holding registers and interrupt generation.
module sci_flag_ctrl
    import sfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [DATA_W-1:0] tx_data,
    output logic              load_req,
    input  logic              sh_idle,
    input  logic              sh_loaded,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              rx_frame_err,
    input  logic              rx_par_err,
    output logic              irq_tx,
    output logic              irq_rx,
    output logic              irq_err
);
    typedef struct packed {
        ctrl_t             ctl;
        logic [DATA_W-1:0] txh;
        logic [DATA_W-1:0] rxh;
    } core_st_t;

    core_st_t st_d, st_q;

    logic [NFLAG-1:0] flag_w;
    logic [NFLAG-1:0] set_v;
    logic [NFLAG-1:0] force_v;
    logic [NFLAG-1:0] wr_zero_v;
    logic             stat_rd;
    logic             stat_wr;
    logic [REG_W-1:0] ctrl_byte;
    logic [REG_W-1:0] stat_byte;
    irq_t             irq_w;

    assign stat_rd = bus_rd && (bus_addr == ADDR_STAT);
    assign stat_wr = bus_wr && (bus_addr == ADDR_STAT);

    // ---------------- register state ----------------
    always_comb begin
        st_d = st_q;
        if (bus_wr) begin
            case (bus_addr)
                ADDR_CTRL: begin
                    st_d.ctl.tie = bus_wdata[CTL_TIE];
                    st_d.ctl.rie = bus_wdata[CTL_RIE];
                    st_d.ctl.te  = bus_wdata[CTL_TE];
                end
                ADDR_TXH: st_d.txh = bus_wdata;
                default: ;
            endcase
        end
        if (rx_done && !flag_w[F_RXF]) begin
            st_d.rxh = rx_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // ---------------- flag events ----------------
    always_comb begin
        set_v          = '0;
        set_v[F_TXE]   = sh_loaded;
        set_v[F_RXF]   = rx_done & ~flag_w[F_RXF];
        set_v[F_ORE]   = rx_done &  flag_w[F_RXF];
        set_v[F_FER]   = rx_done & ~flag_w[F_RXF] & rx_frame_err;
        set_v[F_PER]   = rx_done & ~flag_w[F_RXF] & rx_par_err;
        force_v        = '0;
        force_v[F_TXE] = ~st_q.ctl.te;
        for (int i = 0; i < NFLAG; i++) begin
            wr_zero_v[i] = stat_wr & ~bus_wdata[STAT_TOP - i];
        end
    end

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        sfc_flag #(
            .RESET_VAL(g == F_TXE)
        ) u_flag (
            .clk      (clk),
            .rst_n    (rst_n),
            .set_i    (set_v[g]),
            .force_i  (force_v[g]),
            .rd_hit_i (stat_rd),
            .wr_zero_i(wr_zero_v[g]),
            .flag_o   (flag_w[g])
        );
    end

    // ---------------- read mux ----------------
    always_comb begin
        ctrl_byte          = '0;
        ctrl_byte[CTL_TIE] = st_q.ctl.tie;
        ctrl_byte[CTL_RIE] = st_q.ctl.rie;
        ctrl_byte[CTL_TE]  = st_q.ctl.te;
        stat_byte          = '0;
        for (int i = 0; i < NFLAG; i++) begin
            stat_byte[STAT_TOP - i] = flag_w[i];
        end
        bus_rdata = '0;
        case (bus_addr)
            ADDR_CTRL: bus_rdata[REG_W-1:0] = ctrl_byte;
            ADDR_STAT: bus_rdata[REG_W-1:0] = stat_byte;
            ADDR_TXH:  bus_rdata = st_q.txh;
            default:   bus_rdata = st_q.rxh;
        endcase
    end

    // ---------------- shifter handshake ----------------
    assign tx_data  = st_q.txh;
    assign load_req = st_q.ctl.te & ~flag_w[F_TXE] & sh_idle;

    // ---------------- interrupts ----------------
    sfc_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .flags_i(flag_w),
        .tie_i  (st_q.ctl.tie),
        .rie_i  (st_q.ctl.rie),
        .irq_o  (irq_w)
    );

    assign irq_tx  = irq_w.tx;
    assign irq_rx  = irq_w.rx;
    assign irq_err = irq_w.err;
endmodule

// File: rtl/sfc_checker.sv
// Temporal properties of sci_flag_ctrl, attached by bind.
module sfc_checker
    import sfc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              te,
    input logic              tie,
    input logic              rie,
    input logic [NFLAG-1:0]  flags,
    input logic [DATA_W-1:0] rx_hold,
    input logic              rx_done,
    input logic              sh_loaded,
    input logic              load_req,
    input logic              irq_tx,
    input logic              irq_rx,
    input logic              irq_err,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata
);
    p_irq_tx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_tx == $past(flags[F_TXE] && tie)));

    p_irq_rx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_rx == $past(flags[F_RXF] && rie)));

    p_irq_err_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_err == $past((flags[F_ORE] || flags[F_FER] || flags[F_PER]) && rie)));

    p_rx_store_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !flags[F_RXF]) |=> flags[F_RXF]);

    p_overrun_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && flags[F_RXF]) |=> (flags[F_ORE] && $stable(rx_hold)));

    p_no_bare_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[F_RXF] && !(bus_wr && bus_addr == ADDR_STAT && !bus_wdata[STAT_TOP - F_RXF]))
        |=> flags[F_RXF]);

    p_txe_forced_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !te |=> flags[F_TXE]);

    p_load_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        load_req |-> (te && !flags[F_TXE]));

    p_loaded_sets_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sh_loaded |=> flags[F_TXE]);
endmodule

bind sci_flag_ctrl sfc_checker #(.DATA_W(DATA_W)) u_sfc_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .te       (st_q.ctl.te),
    .tie      (st_q.ctl.tie),
    .rie      (st_q.ctl.rie),
    .flags    (flag_w),
    .rx_hold  (st_q.rxh),
    .rx_done  (rx_done),
    .sh_loaded(sh_loaded),
    .load_req (load_req),
    .irq_tx   (irq_tx),
    .irq_rx   (irq_rx),
    .irq_err  (irq_err),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata)
);

// File: tb/sci_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module sci_flag_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = '0;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] tx_data;
    logic       load_req;
    logic       sh_idle = 1'b1;
    logic       sh_loaded = 1'b0;
    logic       rx_done = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_frame_err = 1'b0;
    logic       rx_par_err = 1'b0;
    logic       irq_tx, irq_rx, irq_err;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    sci_flag_ctrl #(.DATA_W(8)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_data(tx_data), .load_req(load_req),
        .sh_idle(sh_idle), .sh_loaded(sh_loaded),
        .rx_done(rx_done), .rx_data(rx_data),
        .rx_frame_err(rx_frame_err), .rx_par_err(rx_par_err),
        .irq_tx(irq_tx), .irq_rx(irq_rx), .irq_err(irq_err)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_rx(input logic [7:0] d, input logic fe, input logic pe);
        @(negedge clk);
        rx_done = 1'b1; rx_data = d; rx_frame_err = fe; rx_par_err = pe;
        @(negedge clk);
        rx_done = 1'b0; rx_frame_err = 1'b0; rx_par_err = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual 0x01 expected 0x00");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        logic [7:0] exp_st;
        logic [7:0] d;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(2'd0, v); check("R1 ctrl", v, 8'h00);
        rd(2'd1, v); check("R1 status", v, 8'h80);
        check("R1 irqs", {5'b0, irq_tx, irq_rx, irq_err}, 8'h00);
        check("R1 load_req", {7'b0, load_req}, 8'h00);

        // R2 control layout
        wr(2'd0, 8'h1F); rd(2'd0, v); check("R2 low bits", v, 8'h00);
        wr(2'd0, 8'hFF); rd(2'd0, v); check("R2 enables", v, 8'hE0);
        wr(2'd0, 8'h00);

        // R9 empty flag locked while transmitter off
        rd(2'd1, v);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R9 locked", v, 8'h80);

        // R3 sweep of transmit enable with empty flag held at 1
        for (int t = 0; t < 2; t++) begin
            wr(2'd0, t[0] ? 8'h80 : 8'h00);
            tick();
            check("R3 irq_tx", {7'b0, irq_tx}, {7'b0, t[0]});
        end

        wr(2'd0, 8'hA0);
        tick();
        check("R3 irq_tx enabled", {7'b0, irq_tx}, 8'h01);

        // R7 bare write of zero does nothing; read then write clears
        wr(2'd2, 8'h5A);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R7 bare write", v, 8'h80);
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R7 read then clear", v, 8'h00);
        check("R10 load_req", {7'b0, load_req}, 8'h01);
        check("R10 tx_data", tx_data, 8'h5A);
        check("R3 irq_tx low", {7'b0, irq_tx}, 8'h00);
        rd(2'd2, v); check("R2 txh readback", v, 8'h5A);

        @(negedge clk); sh_idle = 1'b0; #1;
        check("R10 shifter busy", {7'b0, load_req}, 8'h00);
        sh_idle = 1'b1; #1;
        check("R10 shifter idle", {7'b0, load_req}, 8'h01);

        // R11 loaded strobe
        @(negedge clk); sh_loaded = 1'b1;
        @(negedge clk); sh_loaded = 1'b0;
        rd(2'd1, v); check("R11 empty set", v, 8'h80);
        check("R3 irq_tx back", {7'b0, irq_tx}, 8'h01);
        check("R10 no request", {7'b0, load_req}, 8'h00);

        // R9 disabling transmitter restores the flag
        wr(2'd1, 8'h00);
        rd(2'd1, v); check("R7 cleared again", v, 8'h00);
        wr(2'd0, 8'h80);
        rd(2'd1, v); check("R9 restored", v, 8'h80);
        check("R9 no request", {7'b0, load_req}, 8'h00);

        // R4 R5 R6 sweep of receive enable and error bits
        for (int k = 0; k < 8; k++) begin
            logic fe, pe, rie;
            fe = k[0]; pe = k[1]; rie = k[2];
            d = 8'(k * 37 + 3);
            wr(2'd0, rie ? 8'h60 : 8'h20);
            pulse_rx(d, fe, pe);
            tick();
            check("R4 irq_rx", {7'b0, irq_rx}, {7'b0, rie});
            check("R4 irq_err", {7'b0, irq_err}, {7'b0, rie & (fe | pe)});
            exp_st = 8'hC0 | (fe ? 8'h10 : 8'h00) | (pe ? 8'h08 : 8'h00);
            rd(2'd1, v); check("R5 status", v, exp_st);
            rd(2'd3, v); check("R5 rx hold", v, d);

            pulse_rx(~d, ~fe, ~pe);
            tick();
            rd(2'd1, v); check("R6 overrun status", v, exp_st | 8'h20);
            rd(2'd3, v); check("R6 hold kept", v, d);
            check("R4 irq_err overrun", {7'b0, irq_err}, {7'b0, rie});

            if (rie) begin
                wr(2'd0, 8'h20);
                tick();
                check("R4 disable drops", {6'b0, irq_rx, irq_err}, 8'h00);
                rd(2'd1, v); check("R4 flags kept", v, exp_st | 8'h20);
            end

            wr(2'd1, 8'h80);
            rd(2'd1, v); check("R7 rx flags cleared", v, 8'h80);
            tick();
            check("R4 irqs idle", {6'b0, irq_rx, irq_err}, 8'h00);
        end

        // R8 writing ones changes nothing
        pulse_rx(8'h3C, 1'b1, 1'b1);
        rd(2'd1, v); check("R8 before", v, 8'hD8);
        wr(2'd1, 8'hFF);
        rd(2'd1, v); check("R8 ones ignored", v, 8'hD8);
        wr(2'd1, 8'h80);
        rd(2'd1, v); check("R7 final clear", v, 8'h80);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule